// File: doc/BRIEF.md
# BCD calendar timekeeper

This block keeps wall-clock time and a calendar as packed BCD fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second tick comes from a divider that counts enable pulses at the reference rate, which is 32.768 kHz by default. On each tick the seconds advance and carries ripple up the fields. The carries apply month lengths and the leap-year rule for a two-digit year.

Software loads any field through a single-cycle write port. Field selector 7 is a control byte whose bit 0 selects the hour encoding. A reset models the loss of all power. After it, the clock holds still until the first write of any kind. Every write restarts the sub-second divider, so the next advance comes one full second after the write.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the outputs read time 00:00:00 in 24-hour form, day of week 0, date 01, month 01, year 00, with 12-hour mode off.
- R2: After reset no field advances until the first write (any selector). After that, the seconds advance once per REF_HZ clock cycles in which ref_pulse is high. Cycles with ref_pulse low make no progress.
- R3: A write loads wr_data into the field chosen by wr_sel (0 second, 1 minute, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 7 control). Unused high bits are dropped: seconds and minutes keep 7 bits, hours and date 6, month 5, day of week 3. Any write clears the divider, so the next advance needs another REF_HZ pulses. A write wins over a tick in the same cycle.
- R4: Seconds wrap from 59 to 00 and advance the minutes. Minutes wrap from 59 to 00 and advance the hours.
- R5: In 24-hour mode the hours run 00 to 23. A wrap from 23 to 00 advances the date and the day of week.
- R6: In 12-hour mode the hour byte holds BCD 01 to 12 in bits 4:0, with bit 5 set for PM. The hour goes from 11 to 12 with the PM bit toggled, and from 12 to 01 with PM kept. Only the step from 11 PM to 12 AM advances the date.
- R7: After the last day of a month the date goes to 01 and the month advances. Months 04, 06, 09 and 11 end at 30, and the other months other than 02 end at 31. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R8: February ends at 29 when the two-digit year, read as a decimal number, is divisible by 4 (00 included). Otherwise it ends at 28.
- R9: The day of week counts 0 to 6, wrapping 6 to 0, and advances on every date change.
- R10: Bit 0 of the control byte selects 12-hour mode (1) or 24-hour mode (0). Changing it leaves the stored hour byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, models total power loss |
| ref_pulse | input | 1 | One-cycle enable at the reference rate |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 8 | BCD byte to write |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD (bit 5 is PM in 12-hour mode) |
| dow_o | output | 3 | Day of week 0 to 6 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| mode12_o | output | 1 | 12-hour mode selected |

## Verification
The bench builds the block with REF_HZ = 4 and holds ref_pulse high. One second is then four clock cycles, so the exact cycle of each advance and of each divider restart can be counted and checked. Fields are loaded right before boundaries: month ends, year 99, February in leap and non-leap years, and 11:59:59 in 12-hour mode. Each carry chain is then covered with a single tick.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_CTRL  = 3'd7
  } field_e;

  // Packed BCD increment, units digit carries into tens
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic logic is_leap(input logic [7:0] year_bcd);
    logic [7:0] b;
    b = bcd_to_bin(year_bcd);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] month_bcd,
                                                input logic [7:0] year_bcd);
    case (month_bcd)
      8'h02:                      return is_leap(year_bcd) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour24_step(input logic [7:0] h);
    return (h == 8'h23) ? 8'h00 : bcd_inc(h);
  endfunction

  // 12-hour step: bit 5 is PM, bits 4:0 hold BCD 01..12
  function automatic logic [7:0] hour12_step(input logic [7:0] h);
    logic [7:0] n;
    if (h[4:0] == 5'h11)      n = {2'b00, ~h[5], 5'h12};
    else if (h[4:0] == 5'h12) n = {2'b00, h[5], 5'h01};
    else begin
      n      = bcd_inc({3'b000, h[4:0]});
      n[5]   = h[5];
      n[7:6] = 2'b00;
    end
    return n;
  endfunction

  function automatic logic hour_is_last(input logic [7:0] h, input logic mode12);
    return mode12 ? (h[5] && h[4:0] == 5'h11) : (h == 8'h23);
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
`timescale 1ns/1ps
module rtc_tick_div #(
  parameter int REF_HZ = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic ref_pulse,
  output logic tick
);
  localparam int CW = (REF_HZ > 2) ? $clog2(REF_HZ) : 1;
  localparam logic [CW-1:0] LAST = CW'(REF_HZ - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = run && !clear && ref_pulse && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clear || !run)   cnt_q <= '0;
    else if (ref_pulse)       cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  // R3: a cleared divider cannot fire on the next cycle
  p_clear_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !tick);

  // R2: no tick without a reference pulse
  p_tick_needs_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_pulse |-> !tick);

endmodule

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode12,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       day_carry
);
  logic sec_last, min_last, hr_last;

  assign sec_last  = (sec_q == 8'h59);
  assign min_last  = (min_q == 8'h59);
  assign hr_last   = hour_is_last(hour_q, mode12);
  assign day_carry = tick && sec_last && min_last && hr_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else if (wr_en) begin
      case (wr_sel)
        FLD_SEC:  sec_q  <= {1'b0, wr_data[6:0]};
        FLD_MIN:  min_q  <= {1'b0, wr_data[6:0]};
        FLD_HOUR: hour_q <= {2'b00, wr_data[5:0]};
        default: ;
      endcase
    end else if (tick) begin
      sec_q <= sec_last ? 8'h00 : bcd_inc(sec_q);
      if (sec_last) begin
        min_q <= min_last ? 8'h00 : bcd_inc(min_q);
        if (min_last)
          hour_q <= mode12 ? hour12_step(hour_q) : hour24_step(hour_q);
      end
    end
  end

  // R4: seconds wrap to zero
  p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && sec_last |=> sec_q == 8'h00);

  // R6: 11 -> 12 in 12-hour mode toggles the PM bit
  p_pm_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && mode12 && sec_last && min_last && hour_q[4:0] == 5'h11
      |=> hour_q[5] != $past(hour_q[5]));

  // R5: 24-hour wrap lands on hour 00
  p_hour_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry && !mode12 |=> hour_q == 8'h00);

endmodule

// File: rtl/rtc_date_chain.sv
`timescale 1ns/1ps
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_step,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [2:0] dow_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q
);
  logic [7:0] last_day;
  logic       month_end, year_end;

  assign last_day  = month_last_day(month_q, year_q);
  assign month_end = (date_q == last_day);
  assign year_end  = (month_q == 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q   <= 3'd0;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else if (wr_en) begin
      case (wr_sel)
        FLD_DOW:   dow_q   <= wr_data[2:0];
        FLD_DATE:  date_q  <= {2'b00, wr_data[5:0]};
        FLD_MONTH: month_q <= {3'b000, wr_data[4:0]};
        FLD_YEAR:  year_q  <= wr_data;
        default: ;
      endcase
    end else if (day_step) begin
      dow_q  <= (dow_q == 3'd6) ? 3'd0 : dow_q + 3'd1;
      date_q <= month_end ? 8'h01 : bcd_inc(date_q);
      if (month_end) begin
        month_q <= year_end ? 8'h01 : bcd_inc(month_q);
        if (year_end)
          year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
      end
    end
  end

  // R9: every date change moves the day of week
  p_dow_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    day_step |=> dow_q != $past(dow_q));

  // R7: the last day of December lands on the first of January
  p_new_year_r7: assert property (@(posedge clk) disable iff (!rst_n)
    day_step && year_end && month_end |=> month_q == 8'h01 && date_q == 8'h01);

  // R8: February 28 never wraps in a leap year
  p_leap_day_r8: assert property (@(posedge clk) disable iff (!rst_n)
    day_step && month_q == 8'h02 && date_q == 8'h28 && is_leap(year_q)
      |=> date_q == 8'h29);

endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int REF_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pulse,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [2:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       mode12_o
);
  logic run_q, mode12_q;
  logic tick, day_carry;

  // Halted after power loss until any write arrives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      mode12_q <= 1'b0;
    end else if (wr_en) begin
      run_q <= 1'b1;
      if (wr_sel == FLD_CTRL) mode12_q <= wr_data[0];
    end
  end

  rtc_tick_div #(.REF_HZ(REF_HZ)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .clear     (wr_en),
    .ref_pulse (ref_pulse),
    .tick      (tick)
  );

  rtc_time_chain u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode12    (mode12_q),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .sec_q     (sec_o),
    .min_q     (min_o),
    .hour_q    (hour_o),
    .day_carry (day_carry)
  );

  rtc_date_chain u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .day_step (day_carry),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .dow_q    (dow_o),
    .date_q   (date_o),
    .month_q  (month_o),
    .year_q   (year_o)
  );

  assign mode12_o = mode12_q;

  // R2: a halted clock does not move without a write
  p_halted_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !wr_en |=> $stable(sec_o) && $stable(min_o) && $stable(date_o));

  // R3: a write suppresses the tick of the same cycle
  p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !tick);

  // R10: format change keeps the stored hour
  p_mode_keeps_hour_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == FLD_CTRL |=> hour_o == $past(hour_o));

endmodule

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;
  localparam int HZ = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_pulse = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
  logic [2:0] dow_o;
  logic       mode12_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_core #(.REF_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .mode12_o(mode12_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic seconds(input int n);
    repeat (n * HZ) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                      input logic [7:0] w, input logic [7:0] h, input logic [7:0] mi,
                      input logic [7:0] s);
    wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d); wr(3'd3, w);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  task automatic t_reset;
    chk("R1 sec", sec_o, 8'h00);
    chk("R1 hour", hour_o, 8'h00);
    chk("R1 date", date_o, 8'h01);
    chk("R1 month", month_o, 8'h01);
    chk("R1 year", year_o, 8'h00);
    chk("R1 dow", {5'd0, dow_o}, 8'h00);
    chk("R1 mode12", {7'd0, mode12_o}, 8'h00);
    repeat (10 * HZ) @(negedge clk);
    chk("R2 halted sec", sec_o, 8'h00);
    chk("R2 halted date", date_o, 8'h01);
  endtask

  task automatic t_start;
    wr(3'd0, 8'h57);
    chk("R3 load sec", sec_o, 8'h57);
    seconds(1);
    chk("R2 first tick", sec_o, 8'h58);
    ref_pulse = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 no ref no progress", sec_o, 8'h58);
    ref_pulse = 1'b1;
    seconds(1);
    chk("R2 resume", sec_o, 8'h59);
  endtask

  task automatic t_divider;
    wr(3'd0, 8'h10);
    repeat (HZ - 1) @(negedge clk);
    chk("R3 before full second", sec_o, 8'h10);
    @(negedge clk);
    chk("R3 full second", sec_o, 8'h11);
    repeat (2) @(negedge clk);
    wr(3'd1, 8'h20);
    chk("R3 write beats tick", sec_o, 8'h11);
    repeat (HZ - 1) @(negedge clk);
    chk("R3 divider restarted", sec_o, 8'h11);
    @(negedge clk);
    chk("R3 tick after restart", sec_o, 8'h12);
    wr(3'd0, 8'hFF);
    chk("R3 sec mask", sec_o, 8'h7F);
    wr(3'd5, 8'hFF);
    chk("R3 month mask", month_o, 8'h1F);
  endtask

  task automatic t_carry;
    load(8'h21, 8'h06, 8'h15, 8'h03, 8'h10, 8'h20, 8'h59);
    seconds(1);
    chk("R4 sec wrap", sec_o, 8'h00);
    chk("R4 min carry", min_o, 8'h21);
    chk("R4 hour kept", hour_o, 8'h10);
    load(8'h21, 8'h06, 8'h15, 8'h03, 8'h23, 8'h59, 8'h59);
    seconds(1);
    chk("R5 hour wrap", hour_o, 8'h00);
    chk("R4 min wrap", min_o, 8'h00);
    chk("R5 date carry", date_o, 8'h16);
    chk("R9 dow follows", {5'd0, dow_o}, 8'h04);
  endtask

  task automatic t_months;
    load(8'h21, 8'h04, 8'h30, 8'h00, 8'h23, 8'h59, 8'h59);
    seconds(1);
    chk("R7 30-day month", month_o, 8'h05);
    chk("R7 30-day date", date_o, 8'h01);
    load(8'h21, 8'h07, 8'h30, 8'h00, 8'h23, 8'h59, 8'h59);
    seconds(1);
    chk("R7 31-day no wrap", date_o, 8'h31);
    load(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    seconds(1);
    chk("R7 year wrap", year_o, 8'h00);
    chk("R7 month wrap", month_o, 8'h01);
    chk("R7 date new year", date_o, 8'h01);
    chk("R9 dow wrap", {5'd0, dow_o}, 8'h00);
  endtask

  task automatic t_leap;
    load(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    seconds(1);
    chk("R8 non-leap month", month_o, 8'h03);
    load(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    seconds(1);
    chk("R8 leap 29th", date_o, 8'h29);
    load(8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
    seconds(1);
    chk("R8 leap end", month_o, 8'h03);
    load(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    seconds(1);
    chk("R8 year 00 leap", date_o, 8'h29);
    load(8'h10, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    seconds(1);
    chk("R8 year 10 not leap", date_o, 8'h01);
  endtask

  task automatic t_12h;
    wr(3'd2, 8'h09);
    wr(3'd7, 8'h01);
    chk("R10 mode on", {7'd0, mode12_o}, 8'h01);
    chk("R10 hour kept", hour_o, 8'h09);
    load(8'h21, 8'h03, 8'h10, 8'h02, 8'h11, 8'h59, 8'h59);
    seconds(1);
    chk("R6 11AM to 12PM", hour_o, 8'h32);
    chk("R6 noon keeps date", date_o, 8'h10);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    seconds(1);
    chk("R6 12PM to 1PM", hour_o, 8'h21);
    wr(3'd2, 8'h31); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    seconds(1);
    chk("R6 11PM to 12AM", hour_o, 8'h12);
    chk("R6 midnight date", date_o, 8'h11);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    seconds(1);
    chk("R6 12AM to 1AM", hour_o, 8'h01);
    wr(3'd7, 8'h00);
    wr(3'd2, 8'h12); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    seconds(1);
    chk("R10 24h after 12", hour_o, 8'h13);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_divider();
    t_carry();
    t_months();
    t_leap();
    t_12h();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule